// File: doc/BRIEF.md
# Double-Buffered Window Configuration Bank

This block holds the per-window setup that a display pipeline needs to fetch and place an overlay. Each window has an enable, a pixel-format code, a buffer base address, the full buffer width and height in pixels, a read offset into the buffer, the screen position of the window's first pixel, the window size, and, for the upper window only, a colour-key value. Every field exists twice. Software writes a staging copy. The pipeline sees only a live copy, and the live copy changes only at a frame boundary.

Software writes any mix of fields and then sets a commit-request bit. At the next vsync pulse every window with a pending commit and a clear hold bit copies its whole staging set into its live set in one step. A window whose hold bit is set keeps its commit pending. It loads at the first vsync after software clears the bit, so a partly written set of fields never reaches the screen. Turning a window off goes through the same path, so scanout of that window stops only at a frame boundary. The bank also derives two values from the live copy: the inclusive last pixel of the window, and the burst size the fetch engine should use.

Top module: `shadow_reg_bank`

## Requirements
- R1: After reset every staging field, every live output, the hold bits and the commit-request readback are zero.
- R2: A register write changes only the staging copy. A read returns the staging copy, never the live one. Address bit 4 is 0 for window registers, bit 3 selects the window, and bits 2:0 select the field: 0 control ({format[4:1], enable[0]}), 1 base, 2 buffer width/height, 3 read offset, 4 first pixel, 5 size, 6 colour key. Fields 2 to 5 hold x or width in bits 11:0 and y or height in bits 27:16. Unmapped addresses read as zero.
- R3: Writing 1 to bit 0 of address 0x11 marks every window pending. A vsync pulse then loads each pending window's staging set into its live set. A vsync with nothing pending changes no live output.
- R4: While a window's hold bit is set (address 0x10, bit n for window n), vsync does not load that window and its commit stays pending. The load happens at the first vsync after the bit is cleared.
- R5: Clearing a window's enable bit leaves the live enable high until the vsync that commits it.
- R6: Bit 0 of address 0x11 reads 1 while any window is pending. It returns to 0 once every window has committed.
- R7: At one vsync, every pending window whose hold bit is clear loads in the same cycle, independently of windows that are held.
- R8: The live last-pixel coordinate is first pixel plus size minus one, each axis modulo 4096. When that sum is zero the result is zero.
- R9: Only window 1 stores a colour key (24 bits). Writes to window 0's key field are ignored, and that field reads and outputs zero.
- R10: The live burst selector is 1 (16-word bursts) when the live buffer width is at least 128 pixels, and 0 (8-word bursts) below that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address (combinational read) |
| rd_data | output | 32 | Read data from the staging copies |
| vsync | input | 1 | Frame-boundary pulse, one cycle |
| act_en | output | 2 | Live window enables |
| act_fmt | output | 8 | Live format codes, 4 bits per window |
| act_base | output | 64 | Live buffer base addresses |
| act_whole_w | output | 24 | Live buffer widths |
| act_whole_h | output | 24 | Live buffer heights |
| act_off_x | output | 24 | Live read offsets, x |
| act_off_y | output | 24 | Live read offsets, y |
| act_tl_x | output | 24 | Live first-pixel x |
| act_tl_y | output | 24 | Live first-pixel y |
| act_br_x | output | 24 | Live inclusive last-pixel x |
| act_br_y | output | 24 | Live inclusive last-pixel y |
| act_key | output | 48 | Live colour keys, 24 bits per window |
| act_burst16 | output | 2 | Live burst selector per window |

## Verification
The hardest state to reach is a commit that stays pending across several frames: a window is held, a request is made, one or more vsync pulses pass, and only then is the hold dropped. Random stimulus rarely lines those steps up. Directed sequences therefore build that case, together with one vsync where both windows commit at once. Constrained random writes, hold changes, requests and vsync pulses then run against a bench model of both the staging and live copies, so pending state carried across frames is compared on every output after each operation.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int DATA_W = 32;
  localparam int CW     = 12;
  localparam int FMT_W  = 4;
  localparam int KEY_W  = 24;
  localparam int REG_W  = 3;
  localparam int Y_LSB  = 16;

  localparam logic [REG_W-1:0] RI_CTRL  = 3'd0;
  localparam logic [REG_W-1:0] RI_BASE  = 3'd1;
  localparam logic [REG_W-1:0] RI_WHOLE = 3'd2;
  localparam logic [REG_W-1:0] RI_OFFS  = 3'd3;
  localparam logic [REG_W-1:0] RI_TL    = 3'd4;
  localparam logic [REG_W-1:0] RI_SIZE  = 3'd5;
  localparam logic [REG_W-1:0] RI_KEY   = 3'd6;

  localparam logic [REG_W-1:0] GI_HOLD  = 3'd0;
  localparam logic [REG_W-1:0] GI_REQ   = 3'd1;

  typedef struct packed {
    logic              en;
    logic [FMT_W-1:0]  fmt;
    logic [DATA_W-1:0] base;
    logic [CW-1:0]     whole_w;
    logic [CW-1:0]     whole_h;
    logic [CW-1:0]     off_x;
    logic [CW-1:0]     off_y;
    logic [CW-1:0]     tl_x;
    logic [CW-1:0]     tl_y;
    logic [CW-1:0]     sz_w;
    logic [CW-1:0]     sz_h;
    logic [KEY_W-1:0]  key;
  } win_cfg_t;
endpackage

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl #(
  parameter int NUM_WIN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic               hold_we,
  input  logic [NUM_WIN-1:0] hold_wdata,
  input  logic               upd_req,
  output logic [NUM_WIN-1:0] hold,
  output logic [NUM_WIN-1:0] pend,
  output logic [NUM_WIN-1:0] load
);
  logic [NUM_WIN-1:0] hold_q, hold_d;
  logic [NUM_WIN-1:0] pend_q, pend_d;

  always_comb begin
    load   = {NUM_WIN{vsync}} & pend_q & ~hold_q;
    pend_d = (pend_q & ~load) | {NUM_WIN{upd_req}};
    hold_d = hold_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_we) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign hold = hold_q;
  assign pend = pend_q;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_chk
    // R6: a committed window leaves the pending set unless re-armed
    a_r6_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (load[i] && !upd_req) |=> !pend[i]);
    // R4: a held window keeps its commit pending
    a_r4_hold_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && hold[i]) |=> pend[i]);
    // R3: a request arms every window
    a_r3_request_arms: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req |=> pend[i]);
  end
endmodule

// File: rtl/shadow_win_regs.sv
module shadow_win_regs
  import shadow_bank_pkg::*;
#(
  parameter int WIN_IDX       = 0,
  parameter int KEY_FIRST_WIN = 1,
  parameter int MIN_BURST_W   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              load,
  output logic              o_en,
  output logic [FMT_W-1:0]  o_fmt,
  output logic [DATA_W-1:0] o_base,
  output logic [CW-1:0]     o_whole_w,
  output logic [CW-1:0]     o_whole_h,
  output logic [CW-1:0]     o_off_x,
  output logic [CW-1:0]     o_off_y,
  output logic [CW-1:0]     o_tl_x,
  output logic [CW-1:0]     o_tl_y,
  output logic [CW-1:0]     o_br_x,
  output logic [CW-1:0]     o_br_y,
  output logic [KEY_W-1:0]  o_key,
  output logic              o_burst16
);
  localparam bit            HAS_KEY = (WIN_IDX >= KEY_FIRST_WIN);
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] BURST_T = CW'(MIN_BURST_W);

  win_cfg_t sh_q, sh_d, act_q;
  logic [CW-1:0] sum_x, sum_y;

  always_comb begin
    sh_d = sh_q;
    case (wr_sel)
      RI_CTRL:  begin sh_d.en = wr_data[0]; sh_d.fmt = wr_data[FMT_W:1]; end
      RI_BASE:  sh_d.base = wr_data;
      RI_WHOLE: begin sh_d.whole_w = wr_data[CW-1:0]; sh_d.whole_h = wr_data[Y_LSB +: CW]; end
      RI_OFFS:  begin sh_d.off_x = wr_data[CW-1:0]; sh_d.off_y = wr_data[Y_LSB +: CW]; end
      RI_TL:    begin sh_d.tl_x = wr_data[CW-1:0]; sh_d.tl_y = wr_data[Y_LSB +: CW]; end
      RI_SIZE:  begin sh_d.sz_w = wr_data[CW-1:0]; sh_d.sz_h = wr_data[Y_LSB +: CW]; end
      RI_KEY:   if (HAS_KEY) sh_d.key = wr_data[KEY_W-1:0];
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (wr_en) begin
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (load) begin
      act_q <= sh_q;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      RI_CTRL:  rd_data[FMT_W:0] = {sh_q.fmt, sh_q.en};
      RI_BASE:  rd_data = sh_q.base;
      RI_WHOLE: begin rd_data[CW-1:0] = sh_q.whole_w; rd_data[Y_LSB +: CW] = sh_q.whole_h; end
      RI_OFFS:  begin rd_data[CW-1:0] = sh_q.off_x;   rd_data[Y_LSB +: CW] = sh_q.off_y;   end
      RI_TL:    begin rd_data[CW-1:0] = sh_q.tl_x;    rd_data[Y_LSB +: CW] = sh_q.tl_y;    end
      RI_SIZE:  begin rd_data[CW-1:0] = sh_q.sz_w;    rd_data[Y_LSB +: CW] = sh_q.sz_h;    end
      RI_KEY:   if (HAS_KEY) rd_data[KEY_W-1:0] = sh_q.key;
      default:  ;
    endcase
  end

  always_comb begin
    sum_x  = act_q.tl_x + act_q.sz_w;
    sum_y  = act_q.tl_y + act_q.sz_h;
    o_br_x = (sum_x == '0) ? '0 : sum_x - ONE;
    o_br_y = (sum_y == '0) ? '0 : sum_y - ONE;
  end

  assign o_en      = act_q.en;
  assign o_fmt     = act_q.fmt;
  assign o_base    = act_q.base;
  assign o_whole_w = act_q.whole_w;
  assign o_whole_h = act_q.whole_h;
  assign o_off_x   = act_q.off_x;
  assign o_off_y   = act_q.off_y;
  assign o_tl_x    = act_q.tl_x;
  assign o_tl_y    = act_q.tl_y;
  assign o_key     = HAS_KEY ? act_q.key : '0;
  assign o_burst16 = (act_q.whole_w >= BURST_T);

  // R2: the live set moves only on a commit strobe from the controller
  a_r2_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
  import shadow_bank_pkg::*;
#(
  parameter int NUM_WIN       = 2,
  parameter int KEY_FIRST_WIN = 1,
  parameter int MIN_BURST_W   = 128,
  localparam int WIN_W        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int ADDR_W       = 1 + WIN_W + REG_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  input  logic                      vsync,
  output logic [NUM_WIN-1:0]        act_en,
  output logic [NUM_WIN*FMT_W-1:0]  act_fmt,
  output logic [NUM_WIN*DATA_W-1:0] act_base,
  output logic [NUM_WIN*CW-1:0]     act_whole_w,
  output logic [NUM_WIN*CW-1:0]     act_whole_h,
  output logic [NUM_WIN*CW-1:0]     act_off_x,
  output logic [NUM_WIN*CW-1:0]     act_off_y,
  output logic [NUM_WIN*CW-1:0]     act_tl_x,
  output logic [NUM_WIN*CW-1:0]     act_tl_y,
  output logic [NUM_WIN*CW-1:0]     act_br_x,
  output logic [NUM_WIN*CW-1:0]     act_br_y,
  output logic [NUM_WIN*KEY_W-1:0]  act_key,
  output logic [NUM_WIN-1:0]        act_burst16
);
  logic             wr_glob, rd_glob;
  logic [WIN_W-1:0] wr_win, rd_win;
  logic [REG_W-1:0] wr_reg, rd_reg;
  logic             hold_we, upd_req;
  logic [NUM_WIN-1:0] hold, pend, load;
  logic [DATA_W-1:0]  win_rd [NUM_WIN];

  always_comb begin
    wr_glob = wr_addr[ADDR_W-1];
    wr_win  = wr_addr[REG_W +: WIN_W];
    wr_reg  = wr_addr[REG_W-1:0];
    rd_glob = rd_addr[ADDR_W-1];
    rd_win  = rd_addr[REG_W +: WIN_W];
    rd_reg  = rd_addr[REG_W-1:0];
    hold_we = wr_en && wr_glob && (wr_reg == GI_HOLD);
    upd_req = wr_en && wr_glob && (wr_reg == GI_REQ) && wr_data[0];
  end

  shadow_commit_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync      (vsync),
    .hold_we    (hold_we),
    .hold_wdata (wr_data[NUM_WIN-1:0]),
    .upd_req    (upd_req),
    .hold       (hold),
    .pend       (pend),
    .load       (load)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic we;
    assign we = wr_en && !wr_glob && (wr_win == WIN_W'(i));

    shadow_win_regs #(
      .WIN_IDX       (i),
      .KEY_FIRST_WIN (KEY_FIRST_WIN),
      .MIN_BURST_W   (MIN_BURST_W)
    ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (we),
      .wr_sel    (wr_reg),
      .wr_data   (wr_data),
      .rd_sel    (rd_reg),
      .rd_data   (win_rd[i]),
      .load      (load[i]),
      .o_en      (act_en[i]),
      .o_fmt     (act_fmt[i*FMT_W +: FMT_W]),
      .o_base    (act_base[i*DATA_W +: DATA_W]),
      .o_whole_w (act_whole_w[i*CW +: CW]),
      .o_whole_h (act_whole_h[i*CW +: CW]),
      .o_off_x   (act_off_x[i*CW +: CW]),
      .o_off_y   (act_off_y[i*CW +: CW]),
      .o_tl_x    (act_tl_x[i*CW +: CW]),
      .o_tl_y    (act_tl_y[i*CW +: CW]),
      .o_br_x    (act_br_x[i*CW +: CW]),
      .o_br_y    (act_br_y[i*CW +: CW]),
      .o_key     (act_key[i*KEY_W +: KEY_W]),
      .o_burst16 (act_burst16[i])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_glob) begin
      if (rd_reg == GI_HOLD) rd_data[NUM_WIN-1:0] = hold;
      else if (rd_reg == GI_REQ) rd_data[0] = |pend;
    end else begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (rd_win == WIN_W'(i)) rd_data = win_rd[i];
      end
    end
  end

  // R5: enables seen by scanout change only on a frame boundary
  a_r5_enable_waits_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(act_en));
endmodule

// File: tb/shadow_reg_bank_bench.sv
module shadow_reg_bank_bench;
  logic        clk, rst_n, wr_en, vsync;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [1:0]  act_en, act_burst16;
  logic [7:0]  act_fmt;
  logic [63:0] act_base;
  logic [23:0] act_whole_w, act_whole_h, act_off_x, act_off_y;
  logic [23:0] act_tl_x, act_tl_y, act_br_x, act_br_y;
  logic [47:0] act_key;

  int nchk = 0;
  int nbad = 0;

  logic [31:0] m_sh  [2][8];
  logic [31:0] m_act [2][8];
  logic [1:0]  m_hold, m_pend;

  shadow_reg_bank u_shadow_reg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vsync(vsync),
    .act_en(act_en), .act_fmt(act_fmt), .act_base(act_base),
    .act_whole_w(act_whole_w), .act_whole_h(act_whole_h),
    .act_off_x(act_off_x), .act_off_y(act_off_y),
    .act_tl_x(act_tl_x), .act_tl_y(act_tl_y),
    .act_br_x(act_br_x), .act_br_y(act_br_y),
    .act_key(act_key), .act_burst16(act_burst16)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] reg_mask(int w, int r);
    case (r)
      0: return 32'h0000_001F;
      1: return 32'hFFFF_FFFF;
      2, 3, 4, 5: return 32'h0FFF_0FFF;
      6: return (w >= 1) ? 32'h00FF_FFFF : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [11:0] f_last(logic [11:0] start, logic [11:0] len);
    logic [11:0] s;
    s = start + len;
    return (s == 12'd0) ? 12'd0 : s - 12'd1;
  endfunction

  function automatic logic f_burst(logic [11:0] w);
    return (w >= 12'd128);
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    if (a[4]) begin
      if (a[2:0] == 3'd0) return {30'd0, m_hold};
      if (a[2:0] == 3'd1) return {31'd0, |m_pend};
      return 32'd0;
    end
    return m_sh[a[3]][a[2:0]];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (!a[4]) m_sh[a[3]][a[2:0]] = d & reg_mask(a[3], a[2:0]);
    else if (a[2:0] == 3'd0) m_hold = d[1:0];
    else if (a[2:0] == 3'd1 && d[0]) m_pend = 2'b11;
  endtask

  task automatic vs();
    @(negedge clk);
    vsync = 1'b1;
    @(posedge clk); #1;
    vsync = 1'b0;
    for (int w = 0; w < 2; w++) begin
      if (m_pend[w] && !m_hold[w]) begin
        for (int r = 0; r < 8; r++) m_act[w][r] = m_sh[w][r];
        m_pend[w] = 1'b0;
      end
    end
  endtask

  task automatic chk_read(logic [4:0] a, string tag);
    rd_addr = a; #1;
    chk(tag, "read", rd_data, exp_read(a));
  endtask

  task automatic chk_outs();
    for (int w = 0; w < 2; w++) begin
      chk("R3", "en",    32'(act_en[w]),             32'(m_act[w][0][0]));
      chk("R3", "fmt",   32'(act_fmt[w*4 +: 4]),     32'(m_act[w][0][4:1]));
      chk("R3", "base",  act_base[w*32 +: 32],       m_act[w][1]);
      chk("R3", "wholew", 32'(act_whole_w[w*12 +: 12]), 32'(m_act[w][2][11:0]));
      chk("R3", "wholeh", 32'(act_whole_h[w*12 +: 12]), 32'(m_act[w][2][27:16]));
      chk("R3", "offx",  32'(act_off_x[w*12 +: 12]), 32'(m_act[w][3][11:0]));
      chk("R3", "offy",  32'(act_off_y[w*12 +: 12]), 32'(m_act[w][3][27:16]));
      chk("R3", "tlx",   32'(act_tl_x[w*12 +: 12]),  32'(m_act[w][4][11:0]));
      chk("R3", "tly",   32'(act_tl_y[w*12 +: 12]),  32'(m_act[w][4][27:16]));
      chk("R8", "brx",   32'(act_br_x[w*12 +: 12]),
          32'(f_last(m_act[w][4][11:0], m_act[w][5][11:0])));
      chk("R8", "bry",   32'(act_br_y[w*12 +: 12]),
          32'(f_last(m_act[w][4][27:16], m_act[w][5][27:16])));
      chk("R9", "key",   32'(act_key[w*24 +: 24]),   32'(m_act[w][6][23:0]));
      chk("R10", "burst", 32'(act_burst16[w]),       32'(f_burst(m_act[w][2][11:0])));
    end
  endtask

  initial begin
    #2_000_000;
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; vsync = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    m_hold = '0; m_pend = '0;
    for (int w = 0; w < 2; w++)
      for (int r = 0; r < 8; r++) begin m_sh[w][r] = '0; m_act[w][r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 32; a++) chk_read(5'(a), "R1");
    chk("R1", "en", 32'(act_en), 32'd0);
    chk("R1", "burst", 32'(act_burst16), 32'd0);
    chk_outs();

    // R2/R3/R6: staging only, commit on request
    wr(5'h00, 32'h0000_000B);
    wr(5'h01, 32'h0000_1000);
    chk("R2", "en before commit", 32'(act_en[0]), 32'd0);
    chk_read(5'h00, "R2");
    vs();
    chk("R3", "en without request", 32'(act_en[0]), 32'd0);
    wr(5'h11, 32'd1);
    rd_addr = 5'h11; #1; chk("R6", "pending readback", rd_data, 32'd1);
    vs();
    chk("R3", "en after commit", 32'(act_en[0]), 32'd1);
    chk("R3", "base after commit", act_base[31:0], 32'h0000_1000);
    rd_addr = 5'h11; #1; chk("R6", "cleared readback", rd_data, 32'd0);

    // R5: disable deferred
    wr(5'h00, 32'd0);
    wr(5'h11, 32'd1);
    chk("R5", "en still on", 32'(act_en[0]), 32'd1);
    repeat (3) @(posedge clk);
    #1 chk("R5", "en on idle", 32'(act_en[0]), 32'd1);
    vs();
    chk("R5", "en off at vsync", 32'(act_en[0]), 32'd0);

    // R4/R7: hold window 0 across frames
    wr(5'h10, 32'd1);
    wr(5'h01, 32'h0000_2000);
    wr(5'h09, 32'h0000_3000);
    wr(5'h11, 32'd1);
    vs();
    chk("R7", "w1 loads", act_base[63:32], 32'h0000_3000);
    chk("R4", "w0 held", act_base[31:0], 32'h0000_1000);
    rd_addr = 5'h11; #1; chk("R6", "still pending", rd_data, 32'd1);
    vs();
    chk("R4", "w0 held 2nd", act_base[31:0], 32'h0000_1000);
    wr(5'h10, 32'd0);
    chk("R4", "w0 no load on release", act_base[31:0], 32'h0000_1000);
    vs();
    chk("R4", "w0 loads after release", act_base[31:0], 32'h0000_2000);
    rd_addr = 5'h11; #1; chk("R6", "all committed", rd_data, 32'd0);
    wr(5'h01, 32'h0000_4000);
    wr(5'h09, 32'h0000_5000);
    wr(5'h11, 32'd1);
    vs();
    chk("R7", "both w0", act_base[31:0], 32'h0000_4000);
    chk("R7", "both w1", act_base[63:32], 32'h0000_5000);

    // R8: inclusive last pixel
    wr(5'h04, (32'd20 << 16) | 32'd10);
    wr(5'h05, (32'd1 << 16) | 32'd5);
    wr(5'h11, 32'd1); vs();
    chk("R8", "brx", 32'(act_br_x[11:0]), 32'd14);
    chk("R8", "bry", 32'(act_br_y[11:0]), 32'd20);
    wr(5'h04, (32'd3 << 16) | 32'hFFF);
    wr(5'h05, 32'd1);
    wr(5'h11, 32'd1); vs();
    chk("R8", "brx zero sum", 32'(act_br_x[11:0]), 32'd0);
    chk("R8", "bry no size", 32'(act_br_y[11:0]), 32'd2);

    // R9: colour key only on window 1
    wr(5'h06, 32'h00AB_CDEF);
    chk_read(5'h06, "R9");
    wr(5'h0E, 32'h12AB_CDEF);
    rd_addr = 5'h0E; #1; chk("R9", "w1 key read", rd_data, 32'h00AB_CDEF);
    wr(5'h11, 32'd1); vs();
    chk("R9", "w1 key live", 32'(act_key[47:24]), 32'h00AB_CDEF);
    chk("R9", "w0 key live", 32'(act_key[23:0]), 32'd0);

    // R10: burst threshold
    wr(5'h02, 32'd127); wr(5'h11, 32'd1); vs();
    chk("R10", "127 wide", 32'(act_burst16[0]), 32'd0);
    wr(5'h02, 32'd128); wr(5'h11, 32'd1); vs();
    chk("R10", "128 wide", 32'(act_burst16[0]), 32'd1);
    chk_outs();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom_range(0, 99);
      if (k < 50) wr(5'($urandom_range(0, 15)), $urandom);
      else if (k < 58) wr(5'h10, 32'($urandom_range(0, 3)));
      else if (k < 73) wr(5'h11, 32'($urandom_range(0, 1)));
      else if (k < 76) wr(5'($urandom_range(16, 31)), $urandom);
      else vs();
      chk_outs();
      chk_read(5'($urandom_range(0, 31)), "R2");
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule